// File: doc/BRIEF.md
# Speculative Store Address Lock Queue

This block holds the addresses of stores that have been issued but have not yet committed. A younger load to any address still held here must wait. A store takes an entry when its address is computed, in the same stage as the cache lookup. Its data arrives later, tagged with the entry index that was returned at allocation. A load probe against the held addresses gives a stall indication in the same cycle.

Entries leave the queue only through in-order commit. A committing store drives the cache array write and the dirty mark, and its entry is freed at the same clock edge. A rollback (flush) empties the whole queue in one cycle. A commit that arrives in the same cycle as a flush is still carried out.

The fill level is tracked by a small state machine with the states `Q_EMPTY`, `Q_PARTIAL` and `Q_FULL`:

| Transition | Condition |
|---|---|
| `Q_EMPTY` to `Q_PARTIAL` | an allocation |
| `Q_PARTIAL` to `Q_FULL` | an allocation that fills the last entry |
| `Q_FULL` to `Q_PARTIAL` | a commit |
| `Q_PARTIAL` to `Q_EMPTY` | the commit of the last entry |
| any state to `Q_EMPTY` | a flush |

The `alloc_ready` output comes from the state.

Top module: `store_lock_queue`

## Requirements
- R1: An accepted allocation (`alloc_valid` with `alloc_ready` high and no flush) stores `alloc_addr` at entry index `alloc_tag`. The next accepted allocation receives that index plus one, wrapping after the last entry.
- R2: `probe_stall` is high in the same cycle whenever `probe_addr[ADDR_W-1:3]` equals the address bits `[ADDR_W-1:3]` of any held entry. It is low otherwise, so the match granularity is 8 bytes.
- R3: `commit_ready` is high only when the oldest entry has received its data. A cycle with `commit_req` and `commit_ready` high drives `wr_en` and `dirty_en` high, with `wr_addr` and `wr_data` taken from that entry. The entry no longer stalls probes from the next cycle.
- R4: Commits retire entries strictly in allocation order. Data that arrives for a younger entry does not make `commit_ready` high while the oldest entry still lacks data.
- R5: Data (`data_valid` with `data_tag`) is recorded only for an index that currently holds an entry. Data sent to an empty index is ignored, and an entry later allocated there still waits for its own data.
- R6: A flush empties the queue by the next cycle. After that edge `probe_stall` and `commit_ready` are low, `alloc_ready` is high and `alloc_tag` is 0.
- R7: When `flush` and a commit occur in the same cycle, the write, the dirty mark and the fetch-window check of that commit are still issued, and then every entry is cleared.
- R8: `fetch_hit` is high in a commit cycle exactly when `wr_addr[ADDR_W-1:6]` equals `fetch_base[ADDR_W-1:6]`, that is, when the store falls in the 64-byte fetch window. It is never high without `wr_en`.
- R9: After reset the queue is empty: `alloc_ready` is high, `probe_stall`, `commit_ready` and `wr_en` are low, and `alloc_tag` is 0.
- R10: When 8 entries are held, `alloc_ready` is low. An allocation attempted then changes neither `alloc_tag` nor the set of held addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A store address is presented |
| alloc_addr | input | ADDR_W | Store address |
| alloc_ready | output | 1 | A free entry exists |
| alloc_tag | output | PTR_W | Index the presented store receives |
| data_valid | input | 1 | Store data is presented |
| data_tag | input | PTR_W | Entry that the data belongs to |
| data_value | input | DATA_W | Store data |
| probe_addr | input | ADDR_W | Load address to check |
| probe_stall | output | 1 | The load must wait |
| commit_req | input | 1 | Retire the oldest store |
| commit_ready | output | 1 | The oldest store holds data |
| wr_en | output | 1 | Cache array write strobe |
| wr_addr | output | ADDR_W | Cache write address |
| wr_data | output | DATA_W | Cache write data |
| dirty_en | output | 1 | Mark the written line dirty |
| fetch_base | input | ADDR_W | Base of the instruction-fetch window |
| fetch_hit | output | 1 | The committing store hits the fetch window, so a rollback is requested |
| flush | input | 1 | Rollback: clear every entry |

## Verification
The probe result and all commit outputs (`wr_en`, `wr_addr`, `wr_data`, `dirty_en`, `fetch_hit`) are combinational. They are due in the same cycle as the probe or commit request. Allocation, data capture and flush take effect on the following edge, so `commit_ready`, `alloc_ready`, `alloc_tag` and the stall state change one cycle after their stimulus. The bench drives inputs just after a falling edge. It samples the combinational results 8 ns later, which is still before the rising edge that registers the request, and it checks registered effects only after that edge has passed.

// File: rtl/slq_pkg.sv
package slq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } fill_state_t;
endpackage

// File: rtl/slq_fsm.sv
module slq_fsm
    import slq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  logic flush,
    output logic alloc_ready,
    output fill_state_t state
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    fill_state_t      state_d;

    always_comb begin
        if (flush) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
        if (cnt_d == '0) begin
            state_d = Q_EMPTY;
        end else if (cnt_d == CNT_W'(DEPTH)) begin
            state_d = Q_FULL;
        end else begin
            state_d = Q_PARTIAL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            state <= Q_EMPTY;
        end else begin
            cnt_q <= cnt_d;
            state <= state_d;
        end
    end

    always_comb begin
        unique case (state)
            Q_EMPTY:   alloc_ready = 1'b1;
            Q_PARTIAL: alloc_ready = 1'b1;
            Q_FULL:    alloc_ready = 1'b0;
            default:   alloc_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/slq_match.sv
module slq_match #(
    parameter int DEPTH     = 8,
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 3
) (
    input  logic [DEPTH-1:0]             held,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addrs,
    input  logic [ADDR_W-1:0]            probe,
    output logic                         hit
);
    logic [DEPTH-1:0] hit_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = held[i] &&
            (addrs[i][ADDR_W-1:GRAN_BITS] == probe[ADDR_W-1:GRAN_BITS]);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/store_lock_queue.sv
module store_lock_queue
    import slq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int DEPTH      = 8,
    parameter int GRAN_BITS  = 3,
    parameter int FETCH_BITS = 6,
    localparam int PTR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    output logic              alloc_ready,
    output logic [PTR_W-1:0]  alloc_tag,
    input  logic              data_valid,
    input  logic [PTR_W-1:0]  data_tag,
    input  logic [DATA_W-1:0] data_value,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_stall,
    input  logic              commit_req,
    output logic              commit_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dirty_en,
    input  logic [ADDR_W-1:0] fetch_base,
    output logic              fetch_hit,
    input  logic              flush
);
    logic [DEPTH-1:0]             ent_valid;
    logic [DEPTH-1:0]             ent_full;
    logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
    logic [DEPTH-1:0][DATA_W-1:0] ent_data;
    logic [PTR_W-1:0]             head, tail;
    logic                         push, pop;
    fill_state_t                  fill_state;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push         = alloc_valid && alloc_ready && !flush;
    assign commit_ready = ent_valid[head] && ent_full[head];
    assign pop          = commit_req && commit_ready;

    assign alloc_tag = tail;
    assign wr_en     = pop;
    assign dirty_en  = pop;
    assign wr_addr   = ent_addr[head];
    assign wr_data   = ent_data[head];
    assign fetch_hit = pop &&
        (ent_addr[head][ADDR_W-1:FETCH_BITS] == fetch_base[ADDR_W-1:FETCH_BITS]);

    slq_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .pop         (pop),
        .flush       (flush),
        .alloc_ready (alloc_ready),
        .state       (fill_state)
    );

    slq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_match (
        .held  (ent_valid),
        .addrs (ent_addr),
        .probe (probe_addr),
        .hit   (probe_stall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_full  <= '0;
            head      <= '0;
            tail      <= '0;
        end else if (flush) begin
            ent_valid <= '0;
            ent_full  <= '0;
            head      <= '0;
            tail      <= '0;
        end else begin
            if (push) begin
                ent_valid[tail] <= 1'b1;
                ent_full[tail]  <= 1'b0;
                tail            <= ptr_inc(tail);
            end
            if (data_valid && ent_valid[data_tag]) begin
                ent_full[data_tag] <= 1'b1;
            end
            if (pop) begin
                ent_valid[head] <= 1'b0;
                ent_full[head]  <= 1'b0;
                head            <= ptr_inc(head);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            ent_addr[tail] <= alloc_addr;
        end
        if (data_valid && ent_valid[data_tag] && !flush) begin
            ent_data[data_tag] <= data_value;
        end
    end
endmodule

// File: rtl/store_lock_queue_chk.sv
module store_lock_queue_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [PTR_W-1:0] alloc_tag,
    input logic             probe_stall,
    input logic             commit_ready,
    input logic             wr_en,
    input logic             dirty_en,
    input logic             fetch_hit,
    input logic             flush
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] occ;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else if (flush) begin
            occ <= '0;
        end else begin
            occ <= occ + CNT_W'(alloc_valid && alloc_ready) - CNT_W'(wr_en);
        end
    end

    p_tag_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !flush) |=>
            (alloc_tag == PTR_W'(($past(alloc_tag) + 1) % DEPTH)));

    p_commit_has_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (occ != '0));

    p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!probe_stall && alloc_ready && !commit_ready && alloc_tag == '0));

    p_fetch_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> (wr_en && dirty_en));

    p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (!probe_stall && !commit_ready));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ready == (occ < CNT_W'(DEPTH)));
endmodule

bind store_lock_queue store_lock_queue_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .PTR_W  (PTR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .alloc_tag    (alloc_tag),
    .probe_stall  (probe_stall),
    .commit_ready (commit_ready),
    .wr_en        (wr_en),
    .dirty_en     (dirty_en),
    .fetch_hit    (fetch_hit),
    .flush        (flush)
);

// File: tb/tb_store_lock_queue.sv
module tb_store_lock_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [31:0] alloc_addr = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        data_valid = 1'b0;
    logic [2:0]  data_tag = '0;
    logic [63:0] data_value = '0;
    logic [31:0] probe_addr = 32'hFFFF_0000;
    logic        probe_stall;
    logic        commit_req = 1'b0;
    logic        commit_ready;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic        dirty_en;
    logic [31:0] fetch_base = 32'hFFFF_FFC0;
    logic        fetch_hit;
    logic        flush = 1'b0;

    typedef struct packed {
        logic [31:0] a;
        logic [2:0]  t;
    } exp_t;

    exp_t        sbq[$];
    logic [63:0] model_data [8];
    int          n_chk = 0;
    int          n_err = 0;

    always #10 clk = ~clk;

    store_lock_queue dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .data_valid(data_valid), .data_tag(data_tag), .data_value(data_value),
        .probe_addr(probe_addr), .probe_stall(probe_stall),
        .commit_req(commit_req), .commit_ready(commit_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dirty_en(dirty_en),
        .fetch_base(fetch_base), .fetch_hit(fetch_hit), .flush(flush)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever the design issues a write
    always begin
        exp_t e;
        @(negedge clk);
        #8;
        if (rst_n && wr_en) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R3 unexpected write", 64'(wr_addr), 64'h0);
            end else begin
                e = sbq.pop_front();
                chk(wr_addr == e.a, "R4 commit order addr", 64'(wr_addr), 64'(e.a));
                chk(wr_data == model_data[e.t], "R3 write data", wr_data, model_data[e.t]);
                chk(dirty_en, "R3 dirty mark", 64'(dirty_en), 64'h1);
                chk(fetch_hit == (e.a[31:6] == fetch_base[31:6]), "R8 fetch hit",
                    64'(fetch_hit), 64'(e.a[31:6] == fetch_base[31:6]));
            end
        end
    end

    task automatic end_cycle();
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
        data_valid  = 1'b0;
        commit_req  = 1'b0;
        flush       = 1'b0;
    endtask

    task automatic do_alloc(input logic [31:0] a, input bit expect_ok,
                            input logic [2:0] exp_tag);
        @(negedge clk);
        alloc_valid = 1'b1;
        alloc_addr  = a;
        #4;
        chk(alloc_ready == expect_ok, "R10 alloc_ready", 64'(alloc_ready), 64'(expect_ok));
        chk(alloc_tag == exp_tag, "R1 alloc tag", 64'(alloc_tag), 64'(exp_tag));
        if (expect_ok) sbq.push_back('{a: a, t: exp_tag});
        end_cycle();
    endtask

    task automatic do_data(input logic [2:0] t, input logic [63:0] v);
        @(negedge clk);
        data_valid = 1'b1;
        data_tag   = t;
        data_value = v;
        model_data[t] = v;
        end_cycle();
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit_req = 1'b1;
        end_cycle();
    endtask

    task automatic probe(input logic [31:0] a, input bit exp_stall, input string req);
        @(negedge clk);
        probe_addr = a;
        #4;
        chk(probe_stall == exp_stall, req, 64'(probe_stall), 64'(exp_stall));
        probe_addr = 32'hFFFF_0000;
    endtask

    task automatic look_ready(input bit exp, input string req);
        @(negedge clk);
        #4;
        chk(commit_ready == exp, req, 64'(commit_ready), 64'(exp));
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #4;
        // R9 reset state
        chk(alloc_ready, "R9 ready after reset", 64'(alloc_ready), 64'h1);
        chk(!probe_stall, "R9 no stall after reset", 64'(probe_stall), 64'h0);
        chk(!commit_ready, "R9 no commit after reset", 64'(commit_ready), 64'h0);
        chk(!wr_en, "R9 no write after reset", 64'(wr_en), 64'h0);
        chk(alloc_tag == 3'd0, "R9 tag after reset", 64'(alloc_tag), 64'h0);

        do_alloc(32'h0000_1000, 1'b1, 3'd0);
        do_alloc(32'h0000_2008, 1'b1, 3'd1);
        do_alloc(32'h0000_3010, 1'b1, 3'd2);

        probe(32'h0000_1004, 1'b1, "R2 same 8-byte word stalls");
        probe(32'h0000_1008, 1'b0, "R2 next word free");
        probe(32'h0000_200F, 1'b1, "R2 upper byte of word stalls");
        probe(32'h0000_3000, 1'b0, "R2 other word free");

        look_ready(1'b0, "R3 no data yet");
        do_data(3'd1, 64'h1111_2222_3333_4444);
        look_ready(1'b0, "R4 younger data does not unblock head");
        do_data(3'd0, 64'hA5A5_0000_FFFF_0001);
        look_ready(1'b1, "R3 head ready with data");
        do_commit();
        do_commit();
        probe(32'h0000_1000, 1'b0, "R3 committed entry released");
        probe(32'h0000_3014, 1'b1, "R2 remaining entry still locks");

        do_data(3'd5, 64'hDEAD_BEEF_DEAD_BEEF); // R5 index 5 is empty
        fetch_base = 32'h0000_3020;              // same 64-byte block as 0x3010

        for (int i = 0; i < 7; i++) begin
            do_alloc(32'h0000_4000 + 32'(i) * 32'h100, 1'b1, 3'((3 + i) % 8));
        end
        do_alloc(32'h0000_9000, 1'b0, 3'd2);     // R10 full, rejected
        probe(32'h0000_9000, 1'b0, "R10 rejected address not held");
        @(negedge clk);
        #4;
        chk(alloc_tag == 3'd2, "R10 tag unchanged when full", 64'(alloc_tag), 64'h2);

        do_data(3'd2, 64'h0202_0202_0202_0202);
        do_commit();                             // R8 fetch window hit
        look_ready(1'b0, "R4 next head lacks data");
        @(negedge clk);
        #4;
        chk(alloc_ready, "R10 ready after commit frees entry", 64'(alloc_ready), 64'h1);
        do_data(3'd3, 64'h0303_0303_0303_0303);
        do_data(3'd4, 64'h0404_0404_0404_0404);
        do_commit();
        do_commit();
        look_ready(1'b0, "R5 data for empty index ignored");
        do_data(3'd5, 64'h0505_0505_0505_0505);
        look_ready(1'b1, "R5 own data accepted");

        // R7 flush together with commit: write of tag 5 still issued
        @(negedge clk);
        commit_req = 1'b1;
        flush      = 1'b1;
        #4;
        chk(wr_en, "R7 commit during flush writes", 64'(wr_en), 64'h1);
        end_cycle();
        sbq.delete();
        @(negedge clk);
        #4;
        chk(alloc_ready, "R6 ready after flush", 64'(alloc_ready), 64'h1);
        chk(!commit_ready, "R6 nothing to commit after flush", 64'(commit_ready), 64'h0);
        chk(alloc_tag == 3'd0, "R6 tag reset by flush", 64'(alloc_tag), 64'h0);
        probe(32'h0000_4300, 1'b0, "R6 flushed entry no longer locks");

        do_alloc(32'h0000_5000, 1'b1, 3'd0);
        probe(32'h0000_5000, 1'b1, "R6 queue usable after flush");
        do_data(3'd0, 64'h5555_6666_7777_8888);
        do_commit();

        repeat (2) @(negedge clk);
        chk(sbq.size() == 0, "R4 all expected writes seen", 64'(sbq.size()), 64'h0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule